// File: doc/BRIEF.md
# Wake Trigger Normalizer

This block sits in front of an interrupt controller that accepts only two kinds of request: rising edges and active-high levels. It takes a bank of raw wake-capable lines and converts each one into a form that controller accepts. Each line has an enable bit and a 3-bit trigger code. A falling edge, or either edge in dual mode, becomes a one-cycle high pulse. An active-low level becomes an active-high level. Each raw line first passes through a two-flop synchronizer, so the inputs may be asynchronous to `clk`.

Software programs the block through a word-wide register port. Enable bits are packed 32 lines to a word. Each line's trigger code sits in its own word. Reads return data one cycle after the request. The normalized outputs are plain request lines with no handshake and no back-pressure. A pulse lasts exactly one clock, and the receiver must sample every cycle. A level stays asserted for as long as its condition holds.

Top module: `wake_trig_norm`

## Requirements
- R1: After reset every output is low and every register reads zero, so each line starts disabled with code 000.
- R2: The enable bit of line n is bit n%32 of the word at byte address 0x10 + 4*(n/32). Writing that word replaces only the bits of lines in that word. Lines in other words keep their enable state.
- R3: The trigger code of line n is held in bits [2:0] of the word at byte address 0x110 + 4*n. Bits [31:3] of that word read as zero.
- R4: The following read as zero, and writes to them have no effect: enable words beyond the last line, enable bits at or above the line count in the last word, code words for n at or above the line count, and every other address.
- R5: `csr_rdata` carries the addressed value in the cycle after `csr_re` is high, and is zero in any cycle that does not follow a read.
- R6: With code 100 (level, active high) and enabled, the output equals the input after a delay of three clock edges.
- R7: With code 000 (level, active low) and enabled, the output equals the inverted input after a delay of three clock edges.
- R8: With code 110 (rising edge) and enabled, each low-to-high input transition gives exactly one high output cycle, three edges later.
- R9: With code 010 (falling edge) and enabled, each high-to-low input transition gives exactly one high output cycle, three edges later.
- R10: With code 111 (dual edge) and enabled, every input transition gives one high output cycle, three edges later.
- R11: A disabled line keeps its output low. A transition that happened while the line was disabled produces no pulse after the line is enabled.
- R12: Lines holding code 001, 011 or 101 keep their output low whatever the input and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after `csr_re` |
| wake_in | input | NUM_LINES | Raw wake lines, asynchronous |
| irq_out | output | NUM_LINES | Normalized request lines toward the controller |

## Verification
The assertions check these rules on every cycle:
- a disabled line, or a line holding an unused code, never drives its output;
- a rising or falling line never pulses on two consecutive cycles while its code is stable;
- read data is zero outside the cycle after a read;
- code words and unmapped addresses never return stray bits.

The exact three-edge latency, the per-mode output shapes and the discarding of transitions while disabled can only be shown by the bench's scenarios. The same applies to the isolation between enable words, which the bench checks against a cycle-level reference model.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [2:0] {
    TRG_LVL_LO = 3'b000,
    TRG_FALL   = 3'b010,
    TRG_LVL_HI = 3'b100,
    TRG_RISE   = 3'b110,
    TRG_DUAL   = 3'b111
  } trig_e;

  localparam int unsigned REG_W       = 32;
  localparam int unsigned EN_BASE_WD  = 4;   // byte 0x10
  localparam int unsigned CFG_BASE_WD = 68;  // byte 0x110

  function automatic logic trig_known(input logic [2:0] code);
    case (code)
      TRG_LVL_LO, TRG_FALL, TRG_LVL_HI, TRG_RISE, TRG_DUAL: trig_known = 1'b1;
      default: trig_known = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/wake_line.sv
module wake_line
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_now,
  input  logic       line_en,
  input  logic [2:0] trig_code,
  output logic       req_out
);

  logic level_prev_q;
  logic req_q;
  logic fire;

  always_comb begin
    case (trig_code)
      TRG_LVL_HI: fire = level_now;
      TRG_LVL_LO: fire = ~level_now;
      TRG_RISE:   fire = level_now & ~level_prev_q;
      TRG_FALL:   fire = ~level_now & level_prev_q;
      TRG_DUAL:   fire = level_now ^ level_prev_q;
      default:    fire = 1'b0;
    endcase
  end

  // History always tracks the input, so edges seen while disabled are lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_prev_q <= 1'b0;
      req_q        <= 1'b0;
    end else begin
      level_prev_q <= level_now;
      req_q        <= line_en & fire;
    end
  end

  assign req_out = req_q;

endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int unsigned NUM_LINES = 168,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csr_we,
  input  logic                   csr_re,
  input  logic [ADDR_W-1:0]      csr_addr,
  input  logic [REG_W-1:0]       csr_wdata,
  output logic [REG_W-1:0]       csr_rdata,
  output logic [NUM_LINES-1:0]   en_vec,
  output logic [3*NUM_LINES-1:0] cfg_flat
);

  localparam int unsigned EN_WORDS = (NUM_LINES + REG_W - 1) / REG_W;
  localparam int unsigned WIDX_W   = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] EN_LO  = WIDX_W'(EN_BASE_WD);
  localparam logic [WIDX_W-1:0] EN_HI  = WIDX_W'(EN_BASE_WD + EN_WORDS);
  localparam logic [WIDX_W-1:0] CFG_LO = WIDX_W'(CFG_BASE_WD);
  localparam logic [WIDX_W-1:0] CFG_HI = WIDX_W'(CFG_BASE_WD + NUM_LINES);

  logic [WIDX_W-1:0] word;
  logic [WIDX_W-1:0] en_idx;
  logic [WIDX_W-1:0] cfg_idx;
  logic              en_hit;
  logic              cfg_hit;
  logic [1:0]        unused_lsb;

  logic [NUM_LINES-1:0]      en_q;
  logic [2:0]                cfg_q [NUM_LINES];
  logic [EN_WORDS*REG_W-1:0] en_padded;
  logic [REG_W-1:0]          rd_val;
  logic [REG_W-1:0]          rdata_q;

  assign word       = csr_addr[ADDR_W-1:2];
  assign unused_lsb = csr_addr[1:0];
  assign en_idx     = word - EN_LO;
  assign cfg_idx    = word - CFG_LO;
  assign en_hit     = (word >= EN_LO) && (word < EN_HI);
  assign cfg_hit    = (word >= CFG_LO) && (word < CFG_HI);

  genvar gb;
  generate
    for (gb = 0; gb < EN_WORDS * REG_W; gb++) begin : g_pad
      if (gb < NUM_LINES) begin : g_live
        assign en_padded[gb] = en_q[gb];
      end else begin : g_dead
        assign en_padded[gb] = 1'b0;
      end
    end
    for (gb = 0; gb < NUM_LINES; gb++) begin : g_flat
      assign cfg_flat[3*gb +: 3] = cfg_q[gb];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int n = 0; n < NUM_LINES; n++) cfg_q[n] <= 3'b000;
    end else if (csr_we) begin
      for (int n = 0; n < NUM_LINES; n++) begin
        if (en_hit && en_idx == WIDX_W'(n / REG_W))
          en_q[n] <= csr_wdata[n % REG_W];
        if (cfg_hit && cfg_idx == WIDX_W'(n))
          cfg_q[n] <= csr_wdata[2:0];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (en_hit) begin
      for (int w = 0; w < EN_WORDS; w++)
        if (en_idx == WIDX_W'(w)) rd_val = en_padded[w*REG_W +: REG_W];
    end else if (cfg_hit) begin
      for (int n = 0; n < NUM_LINES; n++)
        if (cfg_idx == WIDX_W'(n)) rd_val = {{(REG_W-3){1'b0}}, cfg_q[n]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= csr_re ? rd_val : '0;
  end

  assign csr_rdata = rdata_q;
  assign en_vec    = en_q;

endmodule

// File: rtl/wake_trig_norm.sv
module wake_trig_norm
  import wake_pkg::*;
#(
  parameter int unsigned NUM_LINES = 168,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_we,
  input  logic                 csr_re,
  input  logic [ADDR_W-1:0]    csr_addr,
  input  logic [31:0]          csr_wdata,
  output logic [31:0]          csr_rdata,
  input  logic [NUM_LINES-1:0] wake_in,
  output logic [NUM_LINES-1:0] irq_out
);

  logic [NUM_LINES-1:0]   en_vec;
  logic [3*NUM_LINES-1:0] cfg_flat;
  logic [NUM_LINES-1:0]   level_sync;

  wake_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_we   (csr_we),
    .csr_re   (csr_re),
    .csr_addr (csr_addr),
    .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata),
    .en_vec   (en_vec),
    .cfg_flat (cfg_flat)
  );

  wake_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(wake_in),
    .sync_out(level_sync)
  );

  genvar gl;
  generate
    for (gl = 0; gl < NUM_LINES; gl++) begin : g_line
      wake_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_now(level_sync[gl]),
        .line_en  (en_vec[gl]),
        .trig_code(cfg_flat[3*gl +: 3]),
        .req_out  (irq_out[gl])
      );
    end
  endgenerate

endmodule

// File: rtl/wake_trig_norm_chk.sv
module wake_trig_norm_chk
  import wake_pkg::*;
#(
  parameter int unsigned NUM_LINES = 168,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   csr_re,
  input logic [ADDR_W-1:0]      csr_addr,
  input logic [31:0]            csr_rdata,
  input logic [NUM_LINES-1:0]   irq_out,
  input logic [NUM_LINES-1:0]   en_vec,
  input logic [3*NUM_LINES-1:0] cfg_flat
);

  localparam int unsigned EN_WORDS = (NUM_LINES + 31) / 32;
  localparam int unsigned WIDX_W   = ADDR_W - 2;

  logic [NUM_LINES-1:0] live_mask;
  logic [NUM_LINES-1:0] bad_mask;
  logic [NUM_LINES-1:0] rf_mask;
  logic [WIDX_W-1:0]    word;
  logic                 is_cfg;
  logic                 is_mapped;
  logic [1:0]           unused_lsb;

  assign word       = csr_addr[ADDR_W-1:2];
  assign unused_lsb = csr_addr[1:0];
  assign is_cfg     = (word >= WIDX_W'(CFG_BASE_WD)) &&
                      (word <  WIDX_W'(CFG_BASE_WD + NUM_LINES));
  assign is_mapped  = is_cfg || ((word >= WIDX_W'(EN_BASE_WD)) &&
                                 (word <  WIDX_W'(EN_BASE_WD + EN_WORDS)));

  always_comb begin
    for (int n = 0; n < NUM_LINES; n++) begin
      bad_mask[n]  = !trig_known(cfg_flat[3*n +: 3]);
      live_mask[n] = en_vec[n] && !bad_mask[n];
      rf_mask[n]   = (cfg_flat[3*n +: 3] == TRG_RISE) || (cfg_flat[3*n +: 3] == TRG_FALL);
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~$past(live_mask)) == '0); // R11

  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & $past(bad_mask)) == '0); // R12

  AST_SINGLE_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & $past(irq_out) & $past(rf_mask) & $past(rf_mask, 2)) == '0); // R8

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_re) |-> csr_rdata == '0); // R5

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csr_re && is_cfg) |-> csr_rdata[31:3] == '0); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csr_re && !is_mapped) |-> csr_rdata == '0); // R4

endmodule

bind wake_trig_norm wake_trig_norm_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csr_re   (csr_re),
  .csr_addr (csr_addr),
  .csr_rdata(csr_rdata),
  .irq_out  (irq_out),
  .en_vec   (en_vec),
  .cfg_flat (cfg_flat)
);

// File: tb/wake_trig_norm_tb.sv
module wake_trig_norm_tb;

  localparam int N  = 168;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_we = 1'b0;
  logic          csr_re = 1'b0;
  logic [AW-1:0] csr_addr = '0;
  logic [31:0]   csr_wdata = '0;
  logic [31:0]   csr_rdata;
  logic [N-1:0]  wake_in = '0;
  logic [N-1:0]  irq_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  // Reference state, updated from the requirements.
  logic [N-1:0] m_s1, m_s2, m_p, m_out, m_en;
  logic [2:0]   m_cfg [N];

  always #2 clk = ~clk;

  wake_trig_norm #(.NUM_LINES(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_re(csr_re),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .wake_in(wake_in), .irq_out(irq_out)
  );

  function automatic logic mode_fire(input logic [2:0] c, input logic s, input logic p);
    case (c)
      3'b100: return s;           // R6
      3'b000: return !s;          // R7
      3'b110: return s && !p;     // R8
      3'b010: return !s && p;     // R9
      3'b111: return s != p;      // R10
      default: return 1'b0;       // R12
    endcase
  endfunction

  function automatic string tag_of(input logic en, input logic [2:0] c);
    if (!en) return "R11";
    case (c)
      3'b100: return "R6";
      3'b000: return "R7";
      3'b110: return "R8";
      3'b010: return "R9";
      3'b111: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int w;
    logic [31:0] r;
    w = int'(a >> 2);
    r = '0;
    if (w >= 4 && w < 4 + (N + 31) / 32) begin
      for (int b = 0; b < 32; b++)
        if ((w - 4) * 32 + b < N) r[b] = m_en[(w - 4) * 32 + b];
    end else if (w >= 68 && w < 68 + N) begin
      r = {29'b0, m_cfg[w - 68]};
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_out <= '0; m_en <= '0;
      for (int n = 0; n < N; n++) m_cfg[n] <= 3'b000;
    end else begin
      m_s1 <= wake_in;
      m_s2 <= m_s1;
      m_p  <= m_s2;
      for (int n = 0; n < N; n++)
        m_out[n] <= m_en[n] && mode_fire(m_cfg[n], m_s2[n], m_p[n]);
      if (csr_we) begin
        int w;
        w = int'(csr_addr >> 2);
        if (w >= 4 && w < 4 + (N + 31) / 32) begin
          for (int b = 0; b < 32; b++)
            if ((w - 4) * 32 + b < N) m_en[(w - 4) * 32 + b] <= csr_wdata[b];
        end else if (w >= 68 && w < 68 + N) begin
          m_cfg[w - 68] <= csr_wdata[2:0];
        end
      end
    end
  end

  // Per-cycle comparison of every output against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (irq_out !== m_out) begin
        n_errors++;
        for (int n = 0; n < N; n++) begin
          if (irq_out[n] !== m_out[n]) begin
            $display("FAIL %s line %0d: got %b expected %b", tag_of(m_en[n], m_cfg[n]),
                     n, irq_out[n], m_out[n]);
            break;
          end
        end
      end
    end
  end

  task automatic check_val(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = AW'(a); csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    csr_re = 1'b1; csr_addr = AW'(a);
    e = exp_read(AW'(a));
    @(negedge clk);
    csr_re = 1'b0;
    check_val(tag, csr_rdata, e);
  endtask

  task automatic rd_fixed(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    csr_re = 1'b1; csr_addr = AW'(a);
    @(negedge clk);
    csr_re = 1'b0;
    check_val(tag, csr_rdata, e);
  endtask

  task automatic line_is(input int n, input logic v, input string tag);
    check_val(tag, {31'b0, irq_out[n]}, {31'b0, v});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_val("R1 outputs", {31'b0, |irq_out}, 32'd0);
    rd_fixed(32'h10, 32'h0, "R1 enable word0");
    rd_fixed(32'h110, 32'h0, "R1 code line0");
    // R5: idle data is zero
    @(negedge clk);
    check_val("R5 idle rdata", csr_rdata, 32'h0);

    // R2: word isolation
    wr(32'h14, 32'hFFFF_FFFF);
    wr(32'h10, 32'h0000_0000);
    rd_fixed(32'h14, 32'hFFFF_FFFF, "R2 word1 kept");
    wr(32'h14, 32'h0);
    // R4: partial last word, word beyond range
    wr(32'h24, 32'hFFFF_FFFF);
    rd_fixed(32'h24, 32'h0000_00FF, "R4 last word partial");
    wr(32'h28, 32'hFFFF_FFFF);
    rd_fixed(32'h28, 32'h0, "R4 word beyond range");
    wr(32'h24, 32'h0);
    // R3 / R4: code words
    wr(32'h110 + 4 * 167, 32'hFFFF_FFFF);
    rd_fixed(32'h110 + 4 * 167, 32'h7, "R3 code upper bits");
    wr(32'h110 + 4 * 168, 32'hFFFF_FFFF);
    rd_fixed(32'h110 + 4 * 168, 32'h0, "R4 code beyond range");
    rd_fixed(32'h8, 32'h0, "R4 unmapped address");
    wr(32'h110 + 4 * 167, 32'h0);

    // Directed modes on lines 10..15
    wr(32'h110 + 4 * 10, 32'h4);
    wr(32'h110 + 4 * 11, 32'h0);
    wr(32'h110 + 4 * 12, 32'h6);
    wr(32'h110 + 4 * 13, 32'h2);
    wr(32'h110 + 4 * 14, 32'h7);
    wr(32'h110 + 4 * 15, 32'h5);
    wr(32'h10, 32'h0000_FC00);
    repeat (4) @(negedge clk);
    line_is(11, 1'b1, "R7 low input asserts");
    line_is(15, 1'b0, "R12 unused code quiet");
    wake_in[15:10] = 6'h3F;
    repeat (3) @(negedge clk);
    line_is(10, 1'b1, "R6 level high follows");
    line_is(11, 1'b0, "R7 high input releases");
    line_is(12, 1'b1, "R8 rising pulse");
    line_is(13, 1'b0, "R9 no pulse on rise");
    line_is(14, 1'b1, "R10 dual pulse on rise");
    line_is(15, 1'b0, "R12 unused code quiet");
    @(negedge clk);
    line_is(12, 1'b0, "R8 pulse one cycle");
    line_is(14, 1'b0, "R10 pulse one cycle");
    line_is(10, 1'b1, "R6 level held");
    wake_in[15:10] = 6'h00;
    repeat (3) @(negedge clk);
    line_is(10, 1'b0, "R6 level drops");
    line_is(13, 1'b1, "R9 falling pulse");
    line_is(14, 1'b1, "R10 dual pulse on fall");
    line_is(12, 1'b0, "R8 no pulse on fall");
    @(negedge clk);
    line_is(13, 1'b0, "R9 pulse one cycle");

    // R11: edge while disabled is discarded
    wr(32'h110 + 4 * 40, 32'h6);
    wake_in[40] = 1'b1;
    repeat (5) @(negedge clk);
    wr(32'h14, 32'h0000_0100);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      line_is(40, 1'b0, "R11 stale edge dropped");
    end
    wake_in[40] = 1'b0;
    repeat (3) @(negedge clk);
    wake_in[40] = 1'b1;
    repeat (3) @(negedge clk);
    line_is(40, 1'b1, "R11 live after enable");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) begin
        if ($urandom % 2 == 0)
          wr(32'h10 + 4 * int'($urandom % 7), $urandom);
        else
          wr(32'h110 + 4 * int'($urandom % 170), $urandom);
      end else if (r == 1) begin
        if ($urandom % 2 == 0) rd(32'h10 + 4 * int'($urandom % 7), "R2 random enable read");
        else                   rd(32'h110 + 4 * int'($urandom % 170), "R3 random code read");
      end else begin
        logic [191:0] t;
        for (int w = 0; w < 6; w++) t[w*32 +: 32] = $urandom & $urandom;
        @(negedge clk);
        wake_in = wake_in ^ t[N-1:0];
      end
    end

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule